// File: doc/BRIEF.md
# Squared-Spectrum Carrier Peak Estimator

This block sits after a 1024-point frequency transform. The transform runs on a binary phase-keyed signal that has already been squared. Squaring removes the ±1 data modulation and leaves a tone at twice the carrier frequency. The block takes the transform's output as a stream of complex bins and computes each bin's power as the sum of the squares of its real and imaginary parts. It then finds the bin with the strongest power and turns that bin's index into a carrier frequency estimate.

Bin 0 holds the DC term, so the search leaves it out. The upper half of the spectrum mirrors the lower half, so those bins are taken in and thrown away. The winning index marks the doubled carrier. The estimate is therefore the index times a fixed-point resolution constant, halved. A frame begins with a start flag on bin 0. Two cycles after the frame's last bin, the block gives a one-cycle done pulse together with the index and the estimate.

Top module: `sqpk_carrier_est`

## Requirements
- R1: While reset is held and after it is released, `est_done` is 0 and `peak_idx` and `carrier_est` are 0 until the first done pulse.
- R2: Bin power is re*re + im*im, where re and im are 8-bit two's-complement values. The reported peak is the bin with the largest power. This includes the extreme case re = im = -128, whose power is 32768.
- R3: Bin 0 never becomes the peak, even when its power is the largest in the frame.
- R4: Bins 512 to 1023 never become the peak, whatever their power. The candidate bins are 1 to 511.
- R5: When candidate bins have equal power, the lowest index is kept. A later bin replaces the running maximum only if its power is strictly greater.
- R6: `est_done` is high for exactly one cycle. It rises two clock cycles after the cycle in which bin 1023 is presented with `bin_valid` high. It stays low while the frame is streaming.
- R7: On a done pulse, `carrier_est` equals (`peak_idx` × RES_CONST) shifted right by one bit. The default RES_CONST is 9766.
- R8: A frame counts only if it begins with `bin_valid`, `bin_sof` and `bin_idx` = 0 all in the same cycle. Bins streamed without that start produce no done pulse.
- R9: Cycles with `bin_valid` low are ignored, whatever their index and data. Idle gaps inside a frame do not change the result.
- R10: `peak_idx` and `carrier_est` hold their values between done pulses.
- R11: When every candidate bin has power 0, the reported peak is bin 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bin_valid | input | 1 | The bin fields are valid this cycle |
| bin_sof | input | 1 | Frame start flag, meaningful on bin 0 |
| bin_idx | input | 10 | Bin index, 0 to 1023 |
| bin_re | input | 8 | Real part, signed |
| bin_im | input | 8 | Imaginary part, signed |
| est_done | output | 1 | One-cycle pulse when a result is ready |
| peak_idx | output | 10 | Index of the strongest candidate bin |
| carrier_est | output | 25 | Carrier estimate, (peak_idx × RES_CONST) >> 1 |

## Verification
The assertions assume two things about the input stream. Bin indices rise from 0 to 1023 within a frame. A done pulse can only follow a bin 1023 that was presented two cycles earlier. Under those assumptions the assertions check that the peak index stays in 1..511 and that the outputs hold between pulses. The directed frames follow the same rules: every armed frame is streamed in index order, and the next frame starts only after the done pulse has passed. The only departure from the rules is deliberate garbage on idle cycles, which tests that `bin_valid` low is ignored.

// File: rtl/sqpk_pkg.sv
package sqpk_pkg;

   // Policy for equal-power candidates
   typedef enum logic {
      TIE_KEEP_LOW  = 1'b0,
      TIE_KEEP_HIGH = 1'b1
   } tie_e;

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/sqpk_power.sv
// One register stage: bin power plus the aligned index and flags
module sqpk_power #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 10,
   localparam int PROD_W = 2 * DATA_W,
   localparam int POW_W  = 2 * DATA_W + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     in_sof,
   input  logic [IDX_W-1:0]         in_idx,
   input  logic signed [DATA_W-1:0] in_re,
   input  logic signed [DATA_W-1:0] in_im,
   output logic                     pw_valid,
   output logic                     pw_sof,
   output logic [IDX_W-1:0]         pw_idx,
   output logic [POW_W-1:0]         pw_pow
);

   logic signed [PROD_W-1:0] re_ext, im_ext;
   logic signed [PROD_W-1:0] re_sq, im_sq;
   logic [POW_W-1:0]         pow_next;

   always_comb begin
      re_ext   = PROD_W'(in_re);
      im_ext   = PROD_W'(in_im);
      re_sq    = re_ext * re_ext;
      im_sq    = im_ext * im_ext;
      pow_next = {1'b0, re_sq} + {1'b0, im_sq};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pw_valid <= 1'b0;
         pw_sof   <= 1'b0;
         pw_idx   <= '0;
         pw_pow   <= '0;
      end else begin
         pw_valid <= in_valid;
         pw_sof   <= in_sof & in_valid;
         if (in_valid) begin
            pw_idx <= in_idx;
            pw_pow <= pow_next;
         end
      end
   end

endmodule

// File: rtl/sqpk_search.sv
// Running maximum over the candidate bins 1 .. NPTS/2-1
module sqpk_search
   import sqpk_pkg::*;
#(
   parameter int   POW_W      = 17,
   parameter int   NPTS       = 1024,
   parameter tie_e TIE_POLICY = TIE_KEEP_LOW,
   localparam int  IDX_W      = $clog2(NPTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pw_valid,
   input  logic             pw_sof,
   input  logic [IDX_W-1:0] pw_idx,
   input  logic [POW_W-1:0] pw_pow,
   output logic             frame_end,
   output logic [IDX_W-1:0] best_idx
);

   localparam logic [IDX_W-1:0] HALF_IDX = IDX_W'(NPTS / 2);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPTS - 1);
   localparam logic [IDX_W-1:0] FIRST_C  = IDX_W'(1);

   logic             armed;
   logic [POW_W-1:0] best_pow;
   logic             is_start, is_cand, beats;

   generate
      if (TIE_POLICY == TIE_KEEP_LOW) begin : g_tie_low
         assign beats = pw_pow > best_pow;
      end else begin : g_tie_high
         assign beats = pw_pow >= best_pow;
      end
   endgenerate

   always_comb begin
      is_start  = pw_valid && pw_sof && (pw_idx == '0);
      is_cand   = pw_valid && armed && (pw_idx != '0) && (pw_idx < HALF_IDX);
      frame_end = pw_valid && armed && (pw_idx == LAST_IDX);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         best_pow <= '0;
         best_idx <= '0;
      end else if (is_start) begin
         armed    <= 1'b1;
         best_pow <= '0;
         best_idx <= '0;
      end else begin
         if (is_cand && ((pw_idx == FIRST_C) || beats)) begin
            best_pow <= pw_pow;
            best_idx <= pw_idx;
         end
         if (frame_end) begin
            armed <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sqpk_scale.sv
// Result register: peak index and halved fixed-point frequency
module sqpk_scale #(
   parameter int          IDX_W     = 10,
   parameter int          RES_W     = 16,
   parameter int unsigned RES_CONST = 9766,
   localparam int         PROD_W    = IDX_W + RES_W,
   localparam int         EST_W     = IDX_W + RES_W - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_end,
   input  logic [IDX_W-1:0] best_idx,
   output logic             est_done,
   output logic [IDX_W-1:0] peak_idx,
   output logic [EST_W-1:0] carrier_est
);

   localparam logic [PROD_W-1:0] RES_EXT = PROD_W'(RES_CONST);

   logic [PROD_W-1:0] prod;

   always_comb begin
      prod = PROD_W'(best_idx) * RES_EXT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         est_done    <= 1'b0;
         peak_idx    <= '0;
         carrier_est <= '0;
      end else begin
         est_done <= frame_end;
         if (frame_end) begin
            peak_idx    <= best_idx;
            carrier_est <= prod[PROD_W-1:1];
         end
      end
   end

endmodule

// File: rtl/sqpk_carrier_est.sv
module sqpk_carrier_est
   import sqpk_pkg::*;
#(
   parameter int          DATA_W     = 8,
   parameter int          NPTS       = 1024,
   parameter int          RES_W      = 16,
   parameter int unsigned RES_CONST  = 9766,
   parameter tie_e        TIE_POLICY = TIE_KEEP_LOW,
   localparam int         IDX_W      = $clog2(NPTS),
   localparam int         POW_W      = 2 * DATA_W + 1,
   localparam int         EST_W      = IDX_W + RES_W - 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bin_valid,
   input  logic                     bin_sof,
   input  logic [IDX_W-1:0]         bin_idx,
   input  logic signed [DATA_W-1:0] bin_re,
   input  logic signed [DATA_W-1:0] bin_im,
   output logic                     est_done,
   output logic [IDX_W-1:0]         peak_idx,
   output logic [EST_W-1:0]         carrier_est
);

   generate
      if (!is_pow2(NPTS) || NPTS < 8) begin : g_bad_npts
         $error("sqpk_carrier_est: NPTS must be a power of two, at least 8");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("sqpk_carrier_est: DATA_W must be at least 2");
      end
      if (RES_W < 1 || RES_W > 31 || RES_CONST == 0 || RES_CONST >= (32'd1 << RES_W)) begin : g_bad_res
         $error("sqpk_carrier_est: RES_CONST must be nonzero and fit in RES_W bits");
      end
   endgenerate

   logic             pw_valid, pw_sof, frame_end;
   logic [IDX_W-1:0] pw_idx, best_idx;
   logic [POW_W-1:0] pw_pow;

   sqpk_power #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_power (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (bin_valid),
      .in_sof   (bin_sof),
      .in_idx   (bin_idx),
      .in_re    (bin_re),
      .in_im    (bin_im),
      .pw_valid (pw_valid),
      .pw_sof   (pw_sof),
      .pw_idx   (pw_idx),
      .pw_pow   (pw_pow)
   );

   sqpk_search #(.POW_W(POW_W), .NPTS(NPTS), .TIE_POLICY(TIE_POLICY)) u_search (
      .clk       (clk),
      .rst_n     (rst_n),
      .pw_valid  (pw_valid),
      .pw_sof    (pw_sof),
      .pw_idx    (pw_idx),
      .pw_pow    (pw_pow),
      .frame_end (frame_end),
      .best_idx  (best_idx)
   );

   sqpk_scale #(.IDX_W(IDX_W), .RES_W(RES_W), .RES_CONST(RES_CONST)) u_scale (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_end   (frame_end),
      .best_idx    (best_idx),
      .est_done    (est_done),
      .peak_idx    (peak_idx),
      .carrier_est (carrier_est)
   );

endmodule

// File: rtl/sqpk_carrier_est_chk.sv
module sqpk_carrier_est_chk #(
   parameter int DATA_W = 8,
   parameter int NPTS   = 1024,
   parameter int RES_W  = 16,
   localparam int IDX_W = $clog2(NPTS),
   localparam int POW_W = 2 * DATA_W + 1,
   localparam int EST_W = IDX_W + RES_W - 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bin_valid,
   input logic [IDX_W-1:0] bin_idx,
   input logic             est_done,
   input logic [IDX_W-1:0] peak_idx,
   input logic [EST_W-1:0] carrier_est,
   input logic             pw_valid,
   input logic [POW_W-1:0] pw_pow
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPTS - 1);
   localparam logic [IDX_W-1:0] HALF_IDX = IDX_W'(NPTS / 2);
   localparam logic [POW_W-1:0] MAX_POW  = POW_W'(1) << (2 * DATA_W - 1);

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      est_done |=> !est_done); // R6

   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      est_done |-> $past(bin_valid && (bin_idx == LAST_IDX), 2)); // R6

   AST_PEAK_NOT_DC: assert property (@(posedge clk) disable iff (!rst_n)
      est_done |-> (peak_idx != '0)); // R3

   AST_PEAK_LOWER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      est_done |-> (peak_idx < HALF_IDX)); // R4

   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !est_done |-> ($stable(peak_idx) && $stable(carrier_est))); // R10

   AST_POW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pw_valid |-> (pw_pow <= MAX_POW)); // R2

endmodule

bind sqpk_carrier_est sqpk_carrier_est_chk #(
   .DATA_W (DATA_W),
   .NPTS   (NPTS),
   .RES_W  (RES_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bin_valid   (bin_valid),
   .bin_idx     (bin_idx),
   .est_done    (est_done),
   .peak_idx    (peak_idx),
   .carrier_est (carrier_est),
   .pw_valid    (pw_valid),
   .pw_pow      (pw_pow)
);

// File: tb/sqpk_carrier_est_tb.sv
`timescale 1ns/1ps
module sqpk_carrier_est_tb;

   localparam int NPTS = 1024;
   localparam int RES  = 9766;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bin_valid = 1'b0;
   logic              bin_sof = 1'b0;
   logic [9:0]        bin_idx = '0;
   logic signed [7:0] bin_re = '0;
   logic signed [7:0] bin_im = '0;
   logic              est_done;
   logic [9:0]        peak_idx;
   logic [24:0]       carrier_est;

   logic signed [7:0] sre [NPTS];
   logic signed [7:0] sim [NPTS];

   int n_chk = 0;
   int n_err = 0;
   int last_peak = 0;
   longint last_est = 0;

   always #2.5 clk = ~clk;

   sqpk_carrier_est u_dut (
      .clk(clk), .rst_n(rst_n), .bin_valid(bin_valid), .bin_sof(bin_sof),
      .bin_idx(bin_idx), .bin_re(bin_re), .bin_im(bin_im),
      .est_done(est_done), .peak_idx(peak_idx), .carrier_est(carrier_est)
   );

   task automatic check_eq(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic fill_noise();
      for (int i = 0; i < NPTS; i++) begin
         sre[i] = 8'(((i * 7) % 11) - 5);
         sim[i] = 8'(((i * 3) % 9) - 4);
      end
   endtask

   task automatic fill_zero();
      for (int i = 0; i < NPTS; i++) begin
         sre[i] = '0;
         sim[i] = '0;
      end
   endtask

   // Streams one frame; valid-low gap cycles carry garbage (R9)
   task automatic stream(input bit with_sof, input int gap_every, input string req);
      int saw_done = 0;
      for (int i = 0; i < NPTS; i++) begin
         @(negedge clk);
         if (est_done) saw_done++;
         bin_valid = 1'b1;
         bin_sof   = with_sof && (i == 0);
         bin_idx   = 10'(i);
         bin_re    = sre[i];
         bin_im    = sim[i];
         if (gap_every > 0 && (i % gap_every) == gap_every - 1 && i != NPTS - 1) begin
            @(negedge clk);
            if (est_done) saw_done++;
            bin_valid = 1'b0;
            bin_sof   = 1'b1;
            bin_idx   = 10'(NPTS - 1);
            bin_re    = 8'sd127;
            bin_im    = 8'sd127;
         end
      end
      @(negedge clk);
      if (est_done) saw_done++;
      bin_valid = 1'b0;
      bin_sof   = 1'b0;
      check_eq(req, "done during frame", saw_done, 0);
   endtask

   // Armed frame, then check pulse timing and result (R6, R7)
   task automatic run_frame(input int gap_every, input string req, input int exp_peak);
      longint exp_est;
      stream(1'b1, gap_every, req);
      exp_est = (longint'(exp_peak) * RES) >> 1;
      @(negedge clk);
      check_eq("R6", "done two cycles after last bin", est_done, 1);
      check_eq(req, "peak_idx", peak_idx, exp_peak);
      check_eq("R7", "carrier_est", carrier_est, exp_est);
      @(negedge clk);
      check_eq("R6", "done single cycle", est_done, 0);
      check_eq("R10", "peak held", peak_idx, exp_peak);
      last_peak = exp_peak;
      last_est  = exp_est;
   endtask

   task automatic t_reset();
      check_eq("R1", "done in reset", est_done, 0);
      check_eq("R1", "peak in reset", peak_idx, 0);
      check_eq("R1", "est in reset", carrier_est, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_eq("R1", "done after reset", est_done, 0);
      check_eq("R1", "peak after reset", peak_idx, 0);
   endtask

   task automatic t_tone();
      fill_noise();
      sre[100] = 8'sd100;
      sim[100] = -8'sd50;
      run_frame(0, "R2", 100);
   endtask

   task automatic t_dc_and_mirror();
      fill_noise();
      sre[0]   = -8'sd128; sim[0]   = -8'sd128;
      sre[700] = 8'sd127;  sim[700] = 8'sd127;
      sre[512] = 8'sd120;  sim[512] = 8'sd120;
      sre[37]  = 8'sd40;   sim[37]  = 8'sd30;
      run_frame(0, "R3", 37);
      check_eq("R4", "mirror half ignored", peak_idx, 37);
   endtask

   task automatic t_tie();
      fill_noise();
      sre[200] = 8'sd60;  sim[200] = -8'sd80;
      sre[300] = -8'sd80; sim[300] = 8'sd60;
      run_frame(0, "R5", 200);
   endtask

   task automatic t_extreme();
      fill_noise();
      sre[250] = 8'sd127;  sim[250] = 8'sd127;
      sre[511] = -8'sd128; sim[511] = -8'sd128;
      run_frame(0, "R2", 511);
   endtask

   task automatic t_gaps();
      fill_noise();
      sre[5] = 8'sd60; sim[5] = 8'sd60;
      run_frame(3, "R9", 5);
   endtask

   task automatic t_no_start();
      int saw = 0;
      fill_noise();
      sre[9] = 8'sd90; sim[9] = 8'sd90;
      stream(1'b0, 0, "R8");
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (est_done) saw++;
      end
      check_eq("R8", "no done without start", saw, 0);
      check_eq("R10", "peak held without start", peak_idx, last_peak);
      check_eq("R10", "est held without start", carrier_est, last_est);
   endtask

   task automatic t_all_zero();
      fill_zero();
      run_frame(0, "R11", 1);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_tone();
            t_dc_and_mirror();
            t_tie();
            t_extreme();
            t_gaps();
            t_no_start();
            t_all_zero();
         end
         begin
            repeat (150000) @(posedge clk);
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule